// File: doc/BRIEF.md
# Burst-Paced Channel Transmit Controller

This block drives the transmit side of a simplex, point-to-point, word-parallel channel. A local packet source presents words through a valid/ready handshake with a last flag. When a word is waiting, the controller raises a request toward the far end. It waits for the connect answer and then frames the packet. It moves the packet in bursts of a fixed word count and starts each burst only against a receiver-ready credit. Each word leaves with an odd-parity bit. When the packet ends, the controller pulses a disconnect and returns to idle.

Ready pulses from the receiver are counted as credits. A receiver can therefore grant several bursts ahead of time, and those bursts then run with a single idle cycle between them. A packet that is not a whole number of bursts ends with a short burst. Packet length is limited by a byte budget. If the source goes past that budget without a last flag, the packet is cut at the limit and an error strobe is raised. The words that follow go out as a new packet over a new connection.

Top module: `burst_src_ctrl`

## Requirements
- R1: During and right after a synchronous reset (rst high), every channel output and inReady are low, and the burst-ready credit count is zero.
- R2: When inValid is high in idle, chReq rises. While chConnect is low, chReq stays high and inReady, chPacket and chBurst stay low. The framing (chPacket) rises only after chConnect has been seen.
- R3: A burst starts only when at least one credit is held. Each cycle with chRdy high adds one credit while connected, and each burst start removes one. While waiting for connect or for a credit, inReady is low.
- R4: When credits for every burst of a packet are granted ahead of time and the source never stalls, consecutive bursts are separated by exactly one cycle without a data word.
- R5: Every burst except the last of a packet carries exactly BURST_WORDS words, and chBurst is high for exactly the cycles those words are on chData.
- R6: When the packet length is not a multiple of BURST_WORDS, the last burst carries the remainder and chBurst falls after its final word.
- R7: chSop is high with the first word of a packet and chEop with its last word. Both are asserted only with chValid, inside chPacket and chBurst.
- R8: chParity makes the number of ones in {chData, chParity} odd for every valid word.
- R9: A packet holds at most MAX_WORDS = MAX_BYTES/(DATA_W/8) words. If word MAX_WORDS is accepted without inLast, it is sent with chEop and errOverflow high, and the remaining words go out as a new packet after a new request and connect.
- R10: chDisconnect is a one-cycle pulse in the cycle that carries chEop. chReq is low in that cycle, and chPacket and chBurst are low in the cycle after it.
- R11: A word accepted at a clock edge (inValid and inReady high) appears on chData with chValid high in the cycle after that edge, in the order it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Local word available |
| inReady | output | 1 | Controller takes the local word this cycle |
| inData | input | DATA_W | Local word |
| inLast | input | 1 | Local word ends the packet |
| chReq | output | 1 | Connection request to the receiver |
| chConnect | input | 1 | Receiver grants the connection (level) |
| chRdy | input | 1 | Receiver grants one burst per cycle high |
| chPacket | output | 1 | Packet framing |
| chBurst | output | 1 | Burst framing |
| chValid | output | 1 | A word is on chData |
| chData | output | DATA_W | Channel word |
| chParity | output | 1 | Odd-parity bit of chData |
| chSop | output | 1 | First word of the packet |
| chEop | output | 1 | Last word of the packet |
| chDisconnect | output | 1 | Connection ends this cycle |
| errOverflow | output | 1 | Packet cut at the size limit |

## Verification
The bench builds the block with DATA_W=8, BURST_WORDS=4, MAX_BYTES=10 and CREDIT_W=3, so one packet holds at most ten words in up to three bursts. It sweeps every offered length from 1 to 23 words. That covers full and partial last bursts, packets that hit the limit exactly, and lengths that split into two or three packets. Each length runs twice: once with all credits granted up front and once with one credit at a time after a forced wait.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQUEST,
    ST_CONNECTED,
    ST_WAIT_READY,
    ST_BURST,
    ST_DISCONNECT
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic first;
    logic last;
    logic trunc;
  } dpStrobe_t;
endpackage

// File: rtl/bsc_datapath.sv
module bsc_datapath
  import bsc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wordIn,
  output logic              chValid,
  output logic [DATA_W-1:0] chData,
  output logic              chParity,
  output logic              chSop,
  output logic              chEop,
  output logic              errOverflow
);

  always_ff @(posedge clk) begin
    if (rst) begin
      chValid     <= 1'b0;
      chData      <= '0;
      chParity    <= 1'b0;
      chSop       <= 1'b0;
      chEop       <= 1'b0;
      errOverflow <= 1'b0;
    end else begin
      chValid     <= stb.load;
      chSop       <= stb.load & stb.first;
      chEop       <= stb.load & stb.last;
      errOverflow <= stb.load & stb.trunc;
      if (stb.load) begin
        chData   <= wordIn;
        chParity <= ~^wordIn;
      end
    end
  end

  AST_MARKS_NEED_WORD: assert property (@(posedge clk) disable iff (rst)
    (chSop || chEop || errOverflow) |-> chValid); // R7

endmodule

// File: rtl/bsc_control.sv
module bsc_control
  import bsc_pkg::*;
#(
  parameter int BURST_WORDS = 256,
  parameter int MAX_WORDS   = 16384,
  parameter int CREDIT_W    = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      chConnect,
  input  logic      chRdy,
  output logic      inReady,
  output logic      chReq,
  output logic      chPacket,
  output logic      chBurst,
  output logic      chDisconnect,
  output dpStrobe_t stb
);

  localparam int BCNT_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
  localparam int PCNT_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) + 1 : 1;

  ctrlState_t          state, nextState;
  logic [CREDIT_W-1:0] credits;
  logic [BCNT_W-1:0]   burstCnt;
  logic [PCNT_W-1:0]   pktCnt;
  logic take, atLimit, pktEnd, burstEnd, startBurst;

  assign take       = (state == ST_BURST) && inValid;
  assign atLimit    = (pktCnt == PCNT_W'(MAX_WORDS - 1));
  assign pktEnd     = take && (inLast || atLimit);
  assign burstEnd   = take && (burstCnt == BCNT_W'(BURST_WORDS - 1));
  assign startBurst = (state == ST_WAIT_READY) && (credits != '0);

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:       if (inValid)    nextState = ST_REQUEST;
      ST_REQUEST:    if (chConnect)  nextState = ST_CONNECTED;
      ST_CONNECTED:                  nextState = ST_WAIT_READY;
      ST_WAIT_READY: if (startBurst) nextState = ST_BURST;
      ST_BURST: begin
        if (pktEnd)        nextState = ST_DISCONNECT;
        else if (burstEnd) nextState = ST_WAIT_READY;
      end
      ST_DISCONNECT:                 nextState = ST_IDLE;
      default:                       nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      chPacket <= 1'b0;
      chBurst  <= 1'b0;
    end else begin
      state    <= nextState;
      chPacket <= (state == ST_WAIT_READY) || (state == ST_BURST);
      chBurst  <= (state == ST_BURST);
    end
  end

  // credit counter: +1 per ready cycle, -1 per burst start
  always_ff @(posedge clk) begin
    if (rst || state == ST_IDLE) begin
      credits <= '0;
    end else if (chRdy && !startBurst) begin
      if (credits != '1) credits <= credits + 1'b1;
    end else if (!chRdy && startBurst) begin
      credits <= credits - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || startBurst)  burstCnt <= '0;
    else if (take)          burstCnt <= burstCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || state == ST_IDLE) pktCnt <= '0;
    else if (take)               pktCnt <= pktCnt + 1'b1;
  end

  assign inReady      = (state == ST_BURST);
  assign chReq        = (state == ST_REQUEST) || (state == ST_CONNECTED) ||
                        (state == ST_WAIT_READY) || (state == ST_BURST);
  assign chDisconnect = (state == ST_DISCONNECT);

  assign stb.load  = take;
  assign stb.first = take && (pktCnt == '0);
  assign stb.last  = pktEnd;
  assign stb.trunc = take && atLimit && !inLast;

  AST_CONNECT_SEEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONNECTED) |-> $past(chConnect)); // R2

  AST_START_HAS_CREDIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BURST && $past(state) == ST_WAIT_READY) |-> ($past(credits) != '0)); // R3

  AST_PKT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BURST) |-> (int'(pktCnt) < MAX_WORDS)); // R9

endmodule

// File: rtl/burst_src_ctrl.sv
module burst_src_ctrl
  import bsc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BURST_WORDS = (DATA_W == 64) ? 128 : 256,
  parameter int MAX_BYTES   = 65536,
  parameter int CREDIT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              chReq,
  input  logic              chConnect,
  input  logic              chRdy,
  output logic              chPacket,
  output logic              chBurst,
  output logic              chValid,
  output logic [DATA_W-1:0] chData,
  output logic              chParity,
  output logic              chSop,
  output logic              chEop,
  output logic              chDisconnect,
  output logic              errOverflow
);

  localparam int MAX_WORDS = MAX_BYTES / (DATA_W / 8);

  dpStrobe_t stb;

  bsc_control #(
    .BURST_WORDS(BURST_WORDS),
    .MAX_WORDS  (MAX_WORDS),
    .CREDIT_W   (CREDIT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .inLast      (inLast),
    .chConnect   (chConnect),
    .chRdy       (chRdy),
    .inReady     (inReady),
    .chReq       (chReq),
    .chPacket    (chPacket),
    .chBurst     (chBurst),
    .chDisconnect(chDisconnect),
    .stb         (stb)
  );

  bsc_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .wordIn     (inData),
    .chValid    (chValid),
    .chData     (chData),
    .chParity   (chParity),
    .chSop      (chSop),
    .chEop      (chEop),
    .errOverflow(errOverflow)
  );

  AST_DISC_WITH_EOP: assert property (@(posedge clk) disable iff (rst)
    chDisconnect |-> chEop); // R10

  AST_SOP_FRAMED: assert property (@(posedge clk) disable iff (rst)
    chSop |-> (chPacket && chBurst)); // R7

  AST_WORD_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    chValid |-> chBurst); // R5

endmodule

// File: tb/tb_burst_src_ctrl.sv
`timescale 1ns/1ps
module tb_burst_src_ctrl;
  localparam int DW = 8;
  localparam int BW = 4;
  localparam int MW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, inLast = 1'b0, chConnect = 1'b0, chRdy = 1'b0;
  logic [DW-1:0] inData = '0;
  logic inReady, chReq, chPacket, chBurst, chValid, chParity, chSop, chEop;
  logic chDisconnect, errOverflow;
  logic [DW-1:0] chData;

  always #4 clk = ~clk;

  burst_src_ctrl #(.DATA_W(DW), .BURST_WORDS(BW), .MAX_BYTES(MW), .CREDIT_W(3)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .chReq(chReq), .chConnect(chConnect), .chRdy(chRdy),
    .chPacket(chPacket), .chBurst(chBurst), .chValid(chValid), .chData(chData),
    .chParity(chParity), .chSop(chSop), .chEop(chEop),
    .chDisconnect(chDisconnect), .errOverflow(errOverflow));

  int nChk = 0, nFail = 0, cycles = 0;
  int segLen [0:127];
  bit segTrunc [0:127];
  int segWr = 0, segRd = 0;
  bit upfront = 0;
  bit monOn = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] wordOf(input int n);
    return DW'(n * 37 + 5);
  endfunction

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  // channel monitor
  int seqRx = 0, wInPkt = 0, curLen = 0, burstWords = 0, burstStart = 0, gapCnt = 0;
  int connRdy = 0, connBursts = 0;
  bit curTrunc = 0, prevBurst = 0, prevDisc = 0;
  always @(negedge clk) begin
    #1;
    if (monOn) begin
      if (chRdy) connRdy++;
      if (chBurst && !prevBurst) begin
        connBursts++;
        check(connBursts <= connRdy, "R3 burst without credit", connBursts, connRdy);
        burstWords = 0;
        burstStart = wInPkt;
      end
      if (chValid) begin
        if (wInPkt == 0) begin
          curLen = segLen[segRd]; curTrunc = segTrunc[segRd]; gapCnt = 0;
        end
        check(chData == wordOf(seqRx), "R11 data", chData, wordOf(seqRx));
        check((^{chData, chParity}) == 1'b1, "R8 parity", chParity, ~^chData);
        check(chSop == (wInPkt == 0), "R7 sop", chSop, wInPkt == 0);
        check(chEop == (wInPkt == curLen - 1), "R7 eop", chEop, wInPkt == curLen - 1);
        check(chBurst && chPacket, "R5 word framed", {chBurst, chPacket}, 3);
        check(errOverflow == (chEop && curTrunc), "R9 overflow flag", errOverflow, chEop && curTrunc);
        seqRx++; burstWords++; wInPkt++;
        if (wInPkt == curLen) begin
          if (upfront)
            check(gapCnt == (curLen + BW - 1) / BW - 1, "R4 gap cycles", gapCnt, (curLen + BW - 1) / BW - 1);
          wInPkt = 0;
          segRd++;
        end
      end else if (chPacket && wInPkt > 0) begin
        gapCnt++;
      end
      if (!chBurst && prevBurst) begin
        if (curLen - burstStart >= BW)
          check(burstWords == BW, "R5 full burst length", burstWords, BW);
        else
          check(burstWords == curLen - burstStart, "R6 short burst length", burstWords, curLen - burstStart);
      end
      check(chDisconnect == (chValid && chEop), "R10 disconnect with eop", chDisconnect, chValid && chEop);
      if (chDisconnect) begin
        check(!chReq, "R10 request dropped", chReq, 0);
        connRdy = 0; connBursts = 0;
      end
      if (prevDisc) check(!chPacket && !chBurst, "R10 framing off", {chPacket, chBurst}, 0);
      prevBurst = chBurst;
      prevDisc = chDisconnect;
    end
  end

  task automatic feed(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData = wordOf(base + i);
      inLast = (i == len - 1);
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast = 1'b0;
  endtask

  task automatic respond(input int s, input bit up);
    int nb;
    nb = (s + BW - 1) / BW;
    while (!chReq) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(chReq && !inReady && !chPacket && !chBurst, "R2 hold before connect",
            {chReq, inReady, chPacket, chBurst}, 8);
      @(negedge clk);
    end
    chConnect = 1'b1;
    if (up) begin
      for (int b = 0; b < nb; b++) begin
        chRdy = 1'b1; @(negedge clk);
      end
      chRdy = 1'b0;
    end else begin
      for (int b = 0; b < nb; b++) begin
        @(negedge clk); @(negedge clk);
        check(!inReady && !chBurst, "R3 stall without credit", {inReady, chBurst}, 0);
        chRdy = 1'b1; @(negedge clk); chRdy = 1'b0;
        while (!chBurst) @(negedge clk);
        if (b < nb - 1) while (chBurst) @(negedge clk);
      end
    end
    while (!chDisconnect) @(negedge clk);
    chConnect = 1'b0;
  endtask

  int txBase = 0;
  task automatic runPacket(input int len, input bit up);
    int rem, nSeg;
    int segs [0:7];
    upfront = up;
    rem = len; nSeg = 0;
    while (rem > 0) begin
      segs[nSeg] = (rem > MW) ? MW : rem;
      segLen[segWr] = segs[nSeg];
      segTrunc[segWr] = (rem > MW);
      segWr++;
      rem -= segs[nSeg];
      nSeg++;
    end
    fork
      feed(len, txBase);
      begin
        for (int j = 0; j < nSeg; j++) respond(segs[j], up);
      end
    join
    txBase += len;
    repeat (3) @(negedge clk);
    check(segRd == segWr, "R9 packet count", segRd, segWr);
    check(seqRx == txBase, "R11 word count", seqRx, txBase);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({chReq, chPacket, chBurst, chValid, chSop, chEop, chDisconnect, errOverflow, inReady} == '0,
          "R1 outputs low in reset", {chReq, chPacket, chBurst, chValid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({chReq, chPacket, chBurst, chValid, chSop, chEop, chDisconnect, errOverflow, inReady} == '0,
          "R1 outputs low after reset", {chReq, chPacket, chBurst, chValid}, 0);
    chRdy = 1'b1; @(negedge clk); chRdy = 1'b0;
    repeat (2) @(negedge clk);
    check(!chReq && !chBurst, "R1 idle ignores ready", {chReq, chBurst}, 0);
    monOn = 1;
    for (int m = 0; m < 2; m++)
      for (int len = 1; len <= 23; len++)
        runPacket(len, bit'(m));
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule